// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit binary floating-point operands and returns a 32-bit sum one clock after a valid input strobe. Each operand is split into a sign, an 8-bit biased exponent and a 23-bit fraction. A normal value is (-1)^sign x (1 + fraction) x 2^(exponent - 127).

The datapath orders the operands by magnitude and restores the hidden bit. It right-shifts the smaller significand to the larger exponent, keeping guard, round and sticky bits. It then adds or subtracts the significands and normalizes the sum with a leading-zero count. Rounding is to nearest with ties to even, followed by a second normalization when the rounding carries out. Reserved exponent codes are recognized: infinity, NaN and subnormals. The output carries an overflow flag and an underflow flag.

A control module sends a capture strobe to the datapath and produces the output valid. The result register holds its value between valid inputs.

Top module: `fp32_adder`

## Requirements
- R1: Field layout is bit 31 sign, bits 30:23 biased exponent (bias 127), bits 22:0 fraction. Two normal operands whose sum is exact return the exact encoding; 0x40200000 + 0x41400000 gives 0x41680000.
- R2: When inValid is high at a rising edge, outValid is high after that edge and result holds the sum of that edge's operands. When inValid is low, outValid is low after the edge and result and the flags keep their previous values.
- R3: The smaller operand is aligned with guard, round and sticky bits, and the sum is rounded to nearest with ties to even. 0x3F800000 + 0x33800000 gives 0x3F800000. 0x3F800001 + 0x33800000 gives 0x3F800002. 0x3F800000 + 0x33C00000 gives 0x3F800001. 0x3F800000 + 0x33800080 gives 0x3F800001. 0x3F800000 + 0x0D800000 gives 0x3F800000.
- R4: With opposite signs, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger. Leading zeros are removed by a left shift. 0x3F800000 + 0xC0200000 gives 0xBFC00000. 0x3F800001 + 0xBF800000 gives 0x34000000. 0x3F800000 + 0xB0800000 gives 0x3F800000.
- R5: When rounding carries out of the significand, the exponent is raised by one and the fraction becomes zero. 0x3FFFFFFF + 0x33800000 gives 0x40000000.
- R6: A finite sum whose exponent reaches 255, before or after rounding, returns infinity with the sign of the result and raises ovfFlag. 0x7F7FFFFF + 0x7F7FFFFF gives 0x7F800000. 0xFF7FFFFF + 0xFF7FFFFF gives 0xFF800000. 0x7F7FFFFF + 0x73000000 gives 0x7F800000.
- R7: Exponent field 0 with a nonzero fraction is a subnormal with scale 2^-126 and no hidden bit. unfFlag is raised exactly when the returned value is a nonzero subnormal. 0x00000001 + 0x00000001 gives 0x00000002 with unfFlag=1. 0x00400000 + 0x00400000 gives 0x00800000 with unfFlag=0. 0x00800001 + 0x80800000 gives 0x00000001 with unfFlag=1.
- R8: An exponent of 255 with a nonzero fraction is NaN. Any NaN operand, and infinity plus infinity of opposite sign, return the quiet NaN 0x7FC00000 with both flags low.
- R9: An exponent of 255 with a zero fraction is infinity. Infinity plus a finite value or a same-signed infinity returns that infinity with both flags low.
- R10: An exact zero sum of operands with opposite signs is +0 (0x00000000). The sum of two zeros with the same sign keeps that sign. Zero plus x returns x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands are presented this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | result and flags carry a new sum |
| result | output | 32 | Rounded sum |
| ovfFlag | output | 1 | Sum overflowed to infinity |
| unfFlag | output | 1 | Sum is a nonzero subnormal |

## Verification
The bench goes after exact ties, where rounding half away from zero would return an odd fraction. It also uses operands so far apart that only the sticky bit survives; an adder without sticky tracking would break the tie or round wrongly. Rounding carry-out and overflow caused by rounding near the top exponent are probed next, since a design that skips the second normalization would emit a wrong exponent or a finite maximum. Subnormal operands and cancellation down to the subnormal range are checked: a normalization shift not clamped at exponent 1 would produce a garbage exponent. Finally, signed zeros and NaN or infinity combinations are covered, where a careless special-case path returns -0, a signalling payload or a finite number.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
  } fpadd_strobes_t;
endpackage

// File: rtl/fpadd_lzc.sv
module fpadd_lzc #(
  parameter int VEC_W = 27,
  localparam int CNT_W = $clog2(VEC_W + 1)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [CNT_W-1:0] count
);
  logic found;

  always_comb begin
    count = CNT_W'(VEC_W);
    found = 1'b0;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = CNT_W'(VEC_W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpadd_ctrl.sv
module fpadd_ctrl
  import fpadd_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output fpadd_strobes_t strobes,
  output logic           outValid
);
  assign strobes.capture = inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/fpadd_datapath.sv
module fpadd_datapath
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  fpadd_strobes_t          strobes,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic                    ovfFlag,
  output logic                    unfFlag
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int EXT_W  = SIG_W + 3;
  localparam int SUM_W  = EXT_W + 1;
  localparam int RND_W  = SIG_W + 1;
  localparam int XW     = EXP_W + 2;
  localparam int LZ_W   = $clog2(EXT_W + 1);
  localparam logic [EXP_W-1:0]  EXP_TOP = {EXP_W{1'b1}};
  localparam logic [WORD_W-1:0] QNAN = {1'b0, EXP_TOP, 1'b1, {(FRAC_W-1){1'b0}}};

  // Unpack
  logic sA, sB;
  logic [EXP_W-1:0]  eA, eB;
  logic [FRAC_W-1:0] fA, fB;
  assign {sA, eA, fA} = opA;
  assign {sB, eB, fB} = opB;

  logic aNan, bNan, aInf, bInf, nanOut;
  assign aNan   = (&eA) && (|fA);
  assign bNan   = (&eB) && (|fB);
  assign aInf   = (&eA) && !(|fA);
  assign bInf   = (&eB) && !(|fB);
  assign nanOut = aNan || bNan || (aInf && bInf && (sA != sB));

  // Order by magnitude
  logic aBigger, sL, sS, effSub;
  logic [EXP_W-1:0] eL, eS, eLeff, eSeff, diff;
  logic [SIG_W-1:0] mL, mS;
  assign aBigger = {eA, fA} >= {eB, fB};
  assign sL    = aBigger ? sA : sB;
  assign sS    = aBigger ? sB : sA;
  assign eL    = aBigger ? eA : eB;
  assign eS    = aBigger ? eB : eA;
  assign mL    = aBigger ? {|eA, fA} : {|eB, fB};
  assign mS    = aBigger ? {|eB, fB} : {|eA, fA};
  assign eLeff = (eL == '0) ? EXP_W'(1) : eL;
  assign eSeff = (eS == '0) ? EXP_W'(1) : eS;
  assign diff  = eLeff - eSeff;
  assign effSub = sL ^ sS;

  // Align with guard, round, sticky
  logic [EXT_W-1:0] extL, extS, alignS;
  logic stk;
  assign extL = {mL, 3'b000};
  assign extS = {mS, 3'b000};

  always_comb begin
    if (int'(diff) >= EXT_W) begin
      alignS = '0;
      stk    = |extS;
    end else begin
      alignS = extS >> diff;
      stk    = |(extS & ~({EXT_W{1'b1}} << diff));
    end
    alignS[0] = alignS[0] | stk;
  end

  // Add or subtract
  logic [SUM_W-1:0] sum;
  assign sum = effSub ? ({1'b0, extL} - {1'b0, alignS})
                      : ({1'b0, extL} + {1'b0, alignS});

  logic [LZ_W-1:0] lz;
  fpadd_lzc #(.VEC_W(EXT_W)) lzc_i (.vec(sum[EXT_W-1:0]), .count(lz));

  // Normalize, clamped at the smallest exponent
  logic [XW-1:0] limit, lzX, shamt, expN, fieldX;
  logic [EXT_W-1:0] mN;
  assign limit = XW'(eLeff) - XW'(1);
  assign lzX   = XW'(lz);
  assign shamt = (lzX < limit) ? lzX : limit;

  always_comb begin
    if (sum[SUM_W-1]) begin
      mN   = sum[SUM_W-1:1] | EXT_W'(sum[0]);
      expN = XW'(eLeff) + XW'(1);
    end else begin
      mN   = sum[EXT_W-1:0] << shamt;
      expN = XW'(eLeff) - shamt;
    end
  end

  // Round to nearest, ties to even, then renormalize
  logic roundUp;
  logic [RND_W-1:0] rnd;
  logic [FRAC_W-1:0] fracOut;
  assign roundUp = mN[2] & (mN[1] | mN[0] | mN[3]);
  assign rnd     = {1'b0, mN[EXT_W-1:3]} + RND_W'(roundUp);

  always_comb begin
    if (rnd[SIG_W]) begin
      fieldX  = expN + XW'(1);
      fracOut = rnd[SIG_W-1:1];
    end else if (rnd[SIG_W-1]) begin
      fieldX  = expN;
      fracOut = rnd[FRAC_W-1:0];
    end else begin
      fieldX  = '0;
      fracOut = rnd[FRAC_W-1:0];
    end
  end

  // Result selection
  logic [WORD_W-1:0] nxtRes;
  logic nxtOvf, nxtUnf;

  always_comb begin
    nxtOvf = 1'b0;
    nxtUnf = 1'b0;
    if (nanOut)           nxtRes = QNAN;
    else if (aInf)        nxtRes = opA;
    else if (bInf)        nxtRes = opB;
    else if (sum == '0)   nxtRes = {(effSub ? 1'b0 : sL), {(WORD_W-1){1'b0}}};
    else if (fieldX >= XW'(EXP_TOP)) begin
      nxtRes = {sL, EXP_TOP, {FRAC_W{1'b0}}};
      nxtOvf = 1'b1;
    end else begin
      nxtRes = {sL, fieldX[EXP_W-1:0], fracOut};
      nxtUnf = (fieldX == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strobes.capture) begin
      result  <= nxtRes;
      ovfFlag <= nxtOvf;
      unfFlag <= nxtUnf;
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(result) && $stable(ovfFlag) && $stable(unfFlag)));
  // R6
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (result[WORD_W-2:0] == {EXP_TOP, {FRAC_W{1'b0}}}));
  // R7
  unf_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> (result[WORD_W-2:FRAC_W] == '0 && result[FRAC_W-1:0] != '0 && !ovfFlag));
  // R8
  nan_prop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && (aNan || bNan)) |=> (result == QNAN && !ovfFlag && !unfFlag));
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [31:0] result,
  output logic        ovfFlag,
  output logic        unfFlag
);
  fpadd_strobes_t strobes;

  fpadd_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobes(strobes), .outValid(outValid)
  );

  fpadd_datapath #(.EXP_W(8), .FRAC_W(23)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .opA(opA), .opB(opB),
    .result(result), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );
endmodule

// File: tb/fp32_adder_tb_top.sv
`timescale 1ns/1ps
module fp32_adder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic outValid, ovfFlag, unfFlag;
  logic [31:0] result;

  int testsRun = 0;
  int failCount = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [33:0] expect_v;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;

  fp32_adder dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    testsRun++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
               tag, act[33:2], act[1], act[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  // Driver: one operand pair per cycle, expected value pushed to the scoreboard
  task automatic drive(logic [31:0] a, logic [31:0] b, logic [31:0] expRes,
                       logic expOvf, logic expUnf, string tag);
    item_t it;
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    it.expect_v = {expRes, expOvf, expUnf};
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: sample at the falling edge, one cycle after capture
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected outValid", 34'h1, 34'h0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(it.tag, {result, ovfFlag, unfFlag}, it.expect_v);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [33:0] held;
    repeat (3) @(negedge clk);
    check("R2 reset state", {result, ovfFlag, unfFlag}, 34'h0);
    check("R2 reset outValid", {33'h0, outValid}, 34'h0);
    rstN = 1'b1;
    @(negedge clk);

    drive(32'h40200000, 32'h41400000, 32'h41680000, 0, 0, "R1 exact add");
    drive(32'h41400000, 32'h40200000, 32'h41680000, 0, 0, "R1 operand order");
    drive(32'h3F800000, 32'h33800000, 32'h3F800000, 0, 0, "R3 tie to even down");
    drive(32'h3F800001, 32'h33800000, 32'h3F800002, 0, 0, "R3 tie to even up");
    drive(32'h3F800000, 32'h33C00000, 32'h3F800001, 0, 0, "R3 above half");
    drive(32'h3F800000, 32'h33800080, 32'h3F800001, 0, 0, "R3 sticky breaks tie");
    drive(32'h3F800000, 32'h0D800000, 32'h3F800000, 0, 0, "R3 far operand");
    drive(32'h3F800000, 32'hC0200000, 32'hBFC00000, 0, 0, "R4 sign of larger");
    drive(32'h3F800001, 32'hBF800000, 32'h34000000, 0, 0, "R4 cancellation");
    drive(32'h3F800000, 32'hB0800000, 32'h3F800000, 0, 0, "R4 borrow with sticky");
    drive(32'h3FFFFFFF, 32'h33800000, 32'h40000000, 0, 0, "R5 rounding carry");
    drive(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1, 0, "R6 overflow pos");
    drive(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1, 0, "R6 overflow neg");
    drive(32'h7F7FFFFF, 32'h73000000, 32'h7F800000, 1, 0, "R6 overflow by rounding");
    drive(32'h00000001, 32'h00000001, 32'h00000002, 0, 1, "R7 subnormal sum");
    drive(32'h00400000, 32'h00400000, 32'h00800000, 0, 0, "R7 subnormal to normal");
    drive(32'h00800001, 32'h80800000, 32'h00000001, 0, 1, "R7 cancel to subnormal");
    drive(32'h7FC00123, 32'h3F800000, 32'h7FC00000, 0, 0, "R8 nan operand");
    drive(32'h3F800000, 32'hFF800001, 32'h7FC00000, 0, 0, "R8 signalling nan");
    drive(32'h7F800000, 32'hFF800000, 32'h7FC00000, 0, 0, "R8 inf minus inf");
    drive(32'hFF800000, 32'h3F800000, 32'hFF800000, 0, 0, "R9 inf plus finite");
    drive(32'h7F800000, 32'h7F800000, 32'h7F800000, 0, 0, "R9 inf plus inf");
    drive(32'hC0400000, 32'h40400000, 32'h00000000, 0, 0, "R10 exact cancel");
    drive(32'h80000000, 32'h80000000, 32'h80000000, 0, 0, "R10 neg zeros");
    drive(32'h00000000, 32'h80000000, 32'h00000000, 0, 0, "R10 mixed zeros");
    drive(32'h80000000, 32'hC0200000, 32'hC0200000, 0, 0, "R10 zero plus x");

    @(negedge clk);
    inValid = 1'b0;
    opA = 32'h12345678; opB = 32'h9ABCDEF0;
    @(negedge clk);
    held = {result, ovfFlag, unfFlag};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      opA = opA + 32'h01010101;
      check("R2 idle outValid", {33'h0, outValid}, 34'h0);
      check("R2 idle hold", {result, ovfFlag, unfFlag}, held);
    end
    check("R2 scoreboard drained", 34'(expQ.size()), 34'h0);
    finish_run();
  end
endmodule